// File: doc/BRIEF.md
# Blocking-Scheme Line Trip Decision Logic

This block makes the local-end decision for a blocking-type line protection scheme. It receives single-bit detector outputs: a forward overreaching zone, a reverse zone, and a block-received signal from the channel. From these it drives a trip request and a block-transmit signal toward the remote end. A forward fault must persist for a programmed coordination delay before it may trip, which leaves the remote end time to send a block. The trip is then allowed only while no block-received condition is present.

Two timers guard against current reversal on a parallel line. The first is a pickup delay on the reverse zone before it starts blocking. The second is a dropout extension that holds the block after the reverse zone clears. A separate dropout extension stretches the block-received condition. Every timer advances on a periodic tick strobe. The settings arrive on parallel configuration ports and are measured in ticks. An enable input switches the scheme off.

Top module: `dcb_trip_logic`

## Requirements
- R1: With `scheme_en` high and no block-received condition, `trip` is high in the same cycle once `fwd_zone` has been high without a break across `cfg_coord_dly` clock edges at which `tick` was also high. A setting of 0 lets `trip` follow `fwd_zone` in that same cycle.
- R2: `trip` is a level. It is high exactly while the coordination condition holds, `scheme_en` is high and no block-received condition is present. Nothing latches it.
- R3: A low `fwd_zone` at a clock edge clears the coordination count, so a later assertion needs the full `cfg_coord_dly` ticks again.
- R4: The reverse pickup output is high when `rev_zone` is high and has been high across `cfg_rev_pu` ticked edges. While it is high and `scheme_en` is high, `blk_tx` is high.
- R5: After the reverse pickup output drops, `blk_tx` stays high until `cfg_rev_ext` further ticked edges have passed. A setting of 0 removes the hold.
- R6: The block-received condition is `blk_rx`, extended after `blk_rx` falls by `cfg_rx_ext` ticked edges. Any cycle in which this condition holds has `trip` low.
- R7: If `rev_zone` has not been high since reset and the extension has run out, `blk_tx` is low.
- R8: With `scheme_en` low, both `trip` and `blk_tx` are low. The timers keep running, so the outputs take on their enabled values as soon as `scheme_en` returns.
- R9: Clock edges without `tick` neither advance nor expire any timer.
- R10: Synchronous active-high `rst` clears all timers. In the first cycle after reset, `trip` and `blk_tx` reflect only the present inputs with every count at zero.
- R11: A setting of 0 on any timer gives an immediate pickup or dropout, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer strobe, one cycle wide |
| scheme_en | input | 1 | Scheme enable |
| fwd_zone | input | 1 | Forward overreaching zone detect |
| rev_zone | input | 1 | Reverse zone detect |
| blk_rx | input | 1 | Block received from remote end |
| cfg_coord_dly | input | TIMER_W | Coordination delay in ticks |
| cfg_rev_pu | input | TIMER_W | Reverse zone pickup delay in ticks (typical 1) |
| cfg_rev_ext | input | TIMER_W | Reverse block dropout extension in ticks (typical 6) |
| cfg_rx_ext | input | TIMER_W | Block-received dropout extension in ticks (typical 1) |
| trip | output | 1 | Trip request |
| blk_tx | output | 1 | Block transmit toward remote end |

## Verification
The bench builds the block with `TIMER_W` set to 4. At that width the all-ones setting of 15 ticks is short enough to reach many times in a run, so the saturation of the pickup counters and the full reload of the dropout holds are both exercised. Setting groups of all zeros, the typical values (3, 1, 6, 1) and all fifteens are run both as directed sequences and under sticky random stimulus with a sparse tick. Those runs bring forward-zone breaks just before expiry, block-received pulses that hit an expired coordination timer, and enable toggles during active holds.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Typical timer settings, in ticks.
    localparam int unsigned TYP_REV_PU  = 1;
    localparam int unsigned TYP_REV_EXT = 6;
    localparam int unsigned TYP_RX_EXT  = 1;
    localparam int unsigned DEF_TIMER_W = 8;

    // Internal conditions produced by the timer paths.
    typedef struct packed {
        logic coord_ok;   // forward zone held for the coordination delay
        logic rev_pick;   // reverse zone past its pickup delay
        logic rev_blk;    // reverse blocking condition, extended
        logic rx_blk;     // block-received condition, extended
    } dcb_cond_t;

    // Decision from the conditions.
    function automatic logic [1:0] decide(input dcb_cond_t c, input logic en);
        logic [1:0] o;
        o[1] = en & c.coord_ok & ~c.rx_blk;  // trip
        o[0] = en & c.rev_blk;               // block transmit
        return o;
    endfunction

endpackage

// File: rtl/dcb_pickup_timer.sv
module dcb_pickup_timer #(
    parameter int unsigned TW = dcb_pkg::DEF_TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          din,
    input  logic [TW-1:0] limit,
    output logic          dout
);
    logic [TW-1:0] cnt_q;

    // Count ticks while the input holds; saturate at the setting.
    always_ff @(posedge clk) begin
        if (rst || !din) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = din && (cnt_q >= limit);
endmodule

// File: rtl/dcb_dropout_ext.sv
module dcb_dropout_ext #(
    parameter int unsigned TW = dcb_pkg::DEF_TIMER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          din,
    input  logic [TW-1:0] limit,
    output logic          dout
);
    logic [TW-1:0] hold_q;

    // Reload while the input is high, run down on ticks afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (din) begin
            hold_q <= limit;
        end else if (tick && (hold_q != '0)) begin
            hold_q <= hold_q - 1'b1;
        end
    end

    assign dout = din || (hold_q != '0);
endmodule

// File: rtl/dcb_trip_logic.sv
module dcb_trip_logic #(
    parameter int unsigned TIMER_W = dcb_pkg::DEF_TIMER_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               scheme_en,
    input  logic               fwd_zone,
    input  logic               rev_zone,
    input  logic               blk_rx,
    input  logic [TIMER_W-1:0] cfg_coord_dly,
    input  logic [TIMER_W-1:0] cfg_rev_pu,
    input  logic [TIMER_W-1:0] cfg_rev_ext,
    input  logic [TIMER_W-1:0] cfg_rx_ext,
    output logic               trip,
    output logic               blk_tx
);
    import dcb_pkg::*;

    dcb_cond_t cond;
    logic [1:0] dec;

    // Forward path: coordination delay.
    dcb_pickup_timer #(.TW(TIMER_W)) u_coord (
        .clk(clk), .rst(rst), .tick(tick),
        .din(fwd_zone), .limit(cfg_coord_dly), .dout(cond.coord_ok)
    );

    // Reverse path: pickup, then dropout extension.
    dcb_pickup_timer #(.TW(TIMER_W)) u_rev_pu (
        .clk(clk), .rst(rst), .tick(tick),
        .din(rev_zone), .limit(cfg_rev_pu), .dout(cond.rev_pick)
    );

    dcb_dropout_ext #(.TW(TIMER_W)) u_rev_ext (
        .clk(clk), .rst(rst), .tick(tick),
        .din(cond.rev_pick), .limit(cfg_rev_ext), .dout(cond.rev_blk)
    );

    // Receive path: block-received dropout extension.
    dcb_dropout_ext #(.TW(TIMER_W)) u_rx_ext (
        .clk(clk), .rst(rst), .tick(tick),
        .din(blk_rx), .limit(cfg_rx_ext), .dout(cond.rx_blk)
    );

    assign dec    = decide(cond, scheme_en);
    assign trip   = dec[1];
    assign blk_tx = dec[0];
endmodule

// File: rtl/dcb_trip_logic_chk.sv
module dcb_trip_logic_chk #(
    parameter int unsigned TIMER_W = dcb_pkg::DEF_TIMER_W
) (
    input logic               clk,
    input logic               rst,
    input logic               scheme_en,
    input logic               fwd_zone,
    input logic               rev_zone,
    input logic               blk_rx,
    input logic [TIMER_W-1:0] cfg_rx_ext,
    input logic               trip,
    input logic               blk_tx
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    // R8: disabled scheme drives nothing
    a_r8_disable_quiet: assert property (@(posedge clk) disable iff (rst)
        !scheme_en |-> (!trip && !blk_tx));

    // R3: no forward zone, no trip
    a_r3_fwd_needed: assert property (@(posedge clk) disable iff (rst)
        !fwd_zone |-> !trip);

    // R6: live block input suppresses trip
    a_r6_rx_blocks: assert property (@(posedge clk) disable iff (rst)
        blk_rx |-> !trip);

    // R6: stretched block right after block input falls
    a_r6_rx_stretch: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !blk_rx && $past(blk_rx) && cfg_rx_ext != '0) |-> !trip);

    // R4: block transmit starts only from a reverse zone detect
    a_r4_tx_source: assert property (@(posedge clk) disable iff (rst)
        ($rose(blk_tx) && $past(scheme_en)) |-> rev_zone);
endmodule

bind dcb_trip_logic dcb_trip_logic_chk #(.TIMER_W(TIMER_W)) u_chk (
    .clk(clk), .rst(rst), .scheme_en(scheme_en), .fwd_zone(fwd_zone),
    .rev_zone(rev_zone), .blk_rx(blk_rx), .cfg_rx_ext(cfg_rx_ext),
    .trip(trip), .blk_tx(blk_tx)
);

// File: tb/tb_dcb_trip_logic.sv
module tb_dcb_trip_logic;
    localparam int TW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst, tick, scheme_en, fwd_zone, rev_zone, blk_rx;
    logic [TW-1:0] cfg_coord_dly, cfg_rev_pu, cfg_rev_ext, cfg_rx_ext;
    logic trip, blk_tx;

    dcb_trip_logic #(.TIMER_W(TW)) dut (
        .clk(clk), .rst(rst), .tick(tick), .scheme_en(scheme_en),
        .fwd_zone(fwd_zone), .rev_zone(rev_zone), .blk_rx(blk_rx),
        .cfg_coord_dly(cfg_coord_dly), .cfg_rev_pu(cfg_rev_pu),
        .cfg_rev_ext(cfg_rev_ext), .cfg_rx_ext(cfg_rx_ext),
        .trip(trip), .blk_tx(blk_tx)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state: ticks seen, ticks since drop.
    int  m_fwd_ticks, m_rev_ticks, m_rev_since, m_rx_since;
    bit  m_rev_had, m_rx_had;
    bit  e_trip, e_tx, e_rev_pick;

    task automatic check(input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", what, act, exp, cycles);
        end
    endtask

    task automatic model_reset();
        m_fwd_ticks = 0; m_rev_ticks = 0; m_rev_since = 0; m_rx_since = 0;
        m_rev_had = 0; m_rx_had = 0;
    endtask

    function automatic void model_eval();
        bit coord, rev_blk, rx_blk;
        coord      = fwd_zone && (m_fwd_ticks >= int'(cfg_coord_dly));
        e_rev_pick = rev_zone && (m_rev_ticks >= int'(cfg_rev_pu));
        rev_blk    = e_rev_pick || (m_rev_had && m_rev_since < int'(cfg_rev_ext));
        rx_blk     = blk_rx || (m_rx_had && m_rx_since < int'(cfg_rx_ext));
        e_trip     = scheme_en && coord && !rx_blk;
        e_tx       = scheme_en && rev_blk;
    endfunction

    function automatic void model_edge();
        if (fwd_zone) begin if (tick) m_fwd_ticks++; end else m_fwd_ticks = 0;
        if (rev_zone) begin if (tick) m_rev_ticks++; end else m_rev_ticks = 0;
        if (e_rev_pick) begin m_rev_had = 1; m_rev_since = 0; end
        else if (tick) m_rev_since++;
        if (blk_rx) begin m_rx_had = 1; m_rx_since = 0; end
        else if (tick) m_rx_since++;
    endfunction

    // One cycle: drive after the falling edge, compare, then step the model.
    task automatic step(input bit f, input bit r, input bit x, input bit t,
                        input bit e, input string req);
        @(negedge clk);
        fwd_zone = f; rev_zone = r; blk_rx = x; tick = t; scheme_en = e;
        #1;
        model_eval();
        check(trip, e_trip, {req, " trip"});
        check(blk_tx, e_tx, {req, " blk_tx"});
        @(posedge clk);
        model_edge();
    endtask

    task automatic do_reset(input bit f, input bit r);
        @(negedge clk);
        rst = 1; fwd_zone = f; rev_zone = r; blk_rx = 0; tick = 1; scheme_en = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic set_cfg(input int c, input int p, input int re, input int xe);
        cfg_coord_dly = c[TW-1:0]; cfg_rev_pu = p[TW-1:0];
        cfg_rev_ext = re[TW-1:0]; cfg_rx_ext = xe[TW-1:0];
    endtask

    task automatic random_run(input int n, input int tick_pct);
        bit f, r, x, e;
        f = 0; r = 0; x = 0; e = 1;
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(99) < 6)  f = ~f;
            if ($urandom_range(99) < 5)  r = ~r;
            if ($urandom_range(99) < 4)  x = ~x;
            if ($urandom_range(99) < 2)  e = ~e;
            step(f, r, x, ($urandom_range(99) < tick_pct), e, e ? "R2" : "R8");
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(7));
        rst = 1; tick = 0; scheme_en = 0; fwd_zone = 0; rev_zone = 0; blk_rx = 0;
        set_cfg(3, 1, 6, 1);

        // R10: reset clears an active hold; inputs held high through reset
        do_reset(0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 1, "R4");
        do_reset(1, 1);
        #1; model_eval();
        check(trip, 1'b0, "R10 trip after reset");
        check(blk_tx, 1'b0, "R10 blk_tx after reset");
        step(0, 0, 0, 1, 1, "R7");
        check(blk_tx, 1'b0, "R7 no reverse history");

        // R1: coordination delay of 3 ticks
        do_reset(0, 0);
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 0, 1, 1, "R1");
            check(trip, (i >= 3), "R1 coordination expiry");
        end
        // R6: block pulse, then stretched one tick
        step(1, 0, 1, 1, 1, "R6");
        check(trip, 1'b0, "R6 live block");
        step(1, 0, 0, 1, 1, "R6");
        check(trip, 1'b0, "R6 stretched block");
        step(1, 0, 0, 1, 1, "R6");
        check(trip, 1'b1, "R6 block expired");

        // R3: break resets the count
        step(0, 0, 0, 1, 1, "R3");
        for (int i = 0; i < 2; i++) step(1, 0, 0, 1, 1, "R3");
        step(0, 0, 0, 1, 1, "R3");
        for (int i = 0; i < 5; i++) begin
            step(1, 0, 0, 1, 1, "R3");
            check(trip, (i >= 3), "R3 fresh count");
        end

        // R9: no tick, no progress
        step(0, 0, 0, 1, 1, "R9");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 1, "R9");
        check(trip, 1'b0, "R9 timer frozen");

        // R4/R5: pickup 1, extension 6
        do_reset(0, 0);
        for (int i = 0; i < 3; i++) begin
            step(0, 1, 0, 1, 1, "R4");
            check(blk_tx, (i >= 1), "R4 reverse pickup");
        end
        for (int j = 0; j < 8; j++) begin
            step(0, 0, 0, 1, 1, "R5");
            check(blk_tx, (j < 6), "R5 reverse extension");
        end

        // R8: disabled scheme, timers still running
        do_reset(0, 0);
        for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 0, "R8");
        check(trip, 1'b0, "R8 trip disabled");
        check(blk_tx, 1'b0, "R8 blk_tx disabled");
        step(1, 1, 0, 1, 1, "R8");
        check(trip, 1'b1, "R8 re-enabled trip");

        // R11: zero settings act at once
        set_cfg(0, 0, 0, 0);
        do_reset(0, 0);
        step(1, 1, 0, 0, 1, "R11");
        check(trip, 1'b1, "R11 immediate trip");
        check(blk_tx, 1'b1, "R11 immediate block");
        step(0, 0, 0, 0, 1, "R11");
        check(blk_tx, 1'b0, "R11 immediate drop");
        random_run(4000, 30);

        set_cfg(3, 1, 6, 1);
        do_reset(0, 0);
        random_run(8000, 35);

        set_cfg(15, 15, 15, 15);
        do_reset(0, 0);
        random_run(12000, 60);

        set_cfg(5, 2, 3, 4);
        do_reset(0, 0);
        random_run(6000, 100);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule